// File: doc/BRIEF.md
# Wake Event Status Controller

This block gathers wake-up events for a network controller and turns them into a power-management event (PME) request and an interrupt request. Three mode enables select which sources may wake the system: a change of link state, a detected magic wake frame, and a stored-pattern match. Enabled events set sticky detected flags. Every detected flag also sets a single shared PME status flag. That flag drives an active-low PME pin through a PME enable. A magic frame also raises an interrupt flag, which drives an active-low interrupt pin through a global enable and its own enable.

Software reaches the block through a small write port. One address holds the mode enables. A second holds the PME and interrupt enables. A third clears status flags: writing a 1 to a bit clears that flag. There are two resets. The power-on reset clears everything. The bus reset clears status and enables and blocks writes while it is active, but the mode enables keep their values across it. Current status, mode and enable values are brought out on ports.

Top module: `wake_evt_ctrl`

## Requirements
- R1: The mode enables are cleared only by `por_ni`. While `rst_ni` is low, the mode enables keep their values, writes have no effect, and status and control are held at 0.
- R2: When the link mode (mode bit 0) is set, any transition of `link_i` sets the link-detected flag (status bit 0) at the next clock edge. The first `link_i` value after reset is not a transition.
- R3: Setting any detected flag (status bits 0, 1, 2) sets the PME status flag (status bit 4) at the same edge.
- R4: `pme_no` is low exactly when the PME status flag and the PME enable (control bit 0) are both 1.
- R5: A magic-frame pulse with the magic mode (mode bit 1) set sets both the magic-detected flag (status bit 1) and the magic interrupt flag (status bit 3).
- R6: `irq_no` is low exactly when the magic interrupt flag, the global interrupt enable (control bit 1) and the magic interrupt enable (control bit 2) are all 1.
- R7: A pattern-match pulse with the pattern mode (mode bit 2) set sets only the pattern-detected flag (status bit 2) and PME status. It never sets status bits 1 or 3.
- R8: Event inputs whose mode enable is 0 set no flag.
- R9: Writing to address 2 clears each status bit whose data bit is 1. Bits written with 0 are kept. An event arriving in the same cycle as its clear wins, so the flag stays set.
- R10: Address 0 writes the mode enables from data bits 2:0. Address 1 writes the control enables from data bits 2:0. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_ni | input | 1 | Bus reset, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | DATA_W | Write data |
| link_i | input | 1 | Link status level |
| magic_hit_i | input | 1 | Magic frame detected pulse |
| pat_hit_i | input | 1 | Pattern match pulse |
| pme_no | output | 1 | PME request, active low |
| irq_no | output | 1 | Interrupt request, active low |
| status_o | output | 5 | Status flags {pme, magic_int, pat, magic, link} |
| mode_o | output | 3 | Mode enables {pattern, magic, link} |
| ctrl_o | output | 3 | Control enables {magic_int_en, global_int_en, pme_en} |

## Verification
The hardest situation to reach is the collision of an event with a write-one-to-clear in the same cycle. The stimulus issues a full clear on the exact cycle a pattern pulse is presented, and separately on the cycle the link level toggles. In that second case one flag must survive while the others are cleared. The priming of the link detector is also hard to reach. The stimulus holds `link_i` high across a bus reset with link mode kept enabled, then shows that the release of reset raises no link event while a later real toggle does.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned CTRL_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  localparam int unsigned ST_LINK  = 0;
  localparam int unsigned ST_MAGIC = 1;
  localparam int unsigned ST_PAT   = 2;
  localparam int unsigned ST_MINT  = 3;
  localparam int unsigned ST_PME   = 4;
  localparam int unsigned ST_W     = 5;

  typedef struct packed {
    logic pat_en;
    logic magic_en;
    logic link_en;
  } mode_t;

  typedef struct packed {
    logic mint_en;
    logic gie;
    logic pme_en;
  } ctrl_t;
endpackage

// File: rtl/wake_cfg_regs.sv
module wake_cfg_regs
  import wake_pkg::*;
(
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              rst_ni,
  input  logic              sys_rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [MODE_W-1:0] wr_data_i,
  output mode_t             mode_o,
  output ctrl_t             ctrl_o
);
  mode_t mode_q;
  ctrl_t ctrl_q;
  logic  wr_ok;

  // writes are blocked while the bus reset is held
  assign wr_ok = wr_en_i & rst_ni;

  // power-on domain only: survives bus reset
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                                mode_q <= '0;
    else if (wr_ok && wr_addr_i == ADDR_MODE)   mode_q <= mode_t'(wr_data_i);
  end

  always_ff @(posedge clk_i or negedge sys_rst_ni) begin
    if (!sys_rst_ni)                            ctrl_q <= '0;
    else if (wr_ok && wr_addr_i == ADDR_CTRL)   ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
  end

  assign mode_o = mode_q;
  assign ctrl_o = ctrl_q;

  AST_MODE_KEEP_BUS_RST: assert property (@(posedge clk_i) disable iff (!por_ni)
    !rst_ni |=> $stable(mode_q)); // R1
  AST_CTRL_ZERO_IN_RST: assert property (@(posedge clk_i) disable iff (!por_ni)
    !rst_ni |=> ctrl_q == '0); // R1
endmodule

// File: rtl/wake_link_det.sv
module wake_link_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_i,
  input  logic link_en_i,
  output logic evt_o
);
  logic link_q;
  logic prim_q;

  // prim_q suppresses a false edge on the first sample after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q <= 1'b0;
      prim_q <= 1'b0;
    end else begin
      link_q <= link_i;
      prim_q <= 1'b1;
    end
  end

  assign evt_o = prim_q & link_en_i & (link_i ^ link_q);

  AST_LINK_EDGE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(link_i) && prim_q && $past(prim_q) |-> !evt_o); // R2
endmodule

// File: rtl/wake_status.sv
module wake_status
  import wake_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  mode_t           mode_i,
  input  logic            link_evt_i,
  input  logic            magic_i,
  input  logic            pat_i,
  input  logic            clr_en_i,
  input  logic [ST_W-1:0] clr_i,
  output logic [ST_W-1:0] status_o
);
  logic [ST_W-1:0] set_v;
  logic [ST_W-1:0] flag_q;
  logic            magic_evt;
  logic            pat_evt;

  assign magic_evt = magic_i & mode_i.magic_en;
  assign pat_evt   = pat_i & mode_i.pat_en;

  always_comb begin
    set_v           = '0;
    set_v[ST_LINK]  = link_evt_i;
    set_v[ST_MAGIC] = magic_evt;
    set_v[ST_MINT]  = magic_evt;
    set_v[ST_PAT]   = pat_evt;
    set_v[ST_PME]   = link_evt_i | magic_evt | pat_evt;
  end

  // sticky, write-one-to-clear; set wins over clear
  for (genvar i = 0; i < ST_W; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= set_v[i] | (flag_q[i] & ~(clr_en_i & clr_i[i]));
    end
  end

  assign status_o = flag_q;

  AST_LINK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q[ST_LINK] && !clr_en_i |=> flag_q[ST_LINK]); // R2
  AST_PME_CASCADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q[ST_LINK]) || $rose(flag_q[ST_MAGIC]) || $rose(flag_q[ST_PAT])
      |-> flag_q[ST_PME]); // R3
  AST_MAGIC_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q[ST_MINT]) |-> flag_q[ST_MAGIC]); // R5
  AST_PAT_NO_MAGIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !magic_i && !flag_q[ST_MAGIC] && !flag_q[ST_MINT]
      |=> !flag_q[ST_MAGIC] && !flag_q[ST_MINT]); // R7
  AST_IGNORE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i.magic_en && !mode_i.pat_en |=> !$rose(flag_q[ST_MAGIC]) && !$rose(flag_q[ST_PAT])); // R8
  AST_PME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q[ST_PME] && !clr_en_i |=> flag_q[ST_PME]); // R9
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
  import wake_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              link_i,
  input  logic              magic_hit_i,
  input  logic              pat_hit_i,
  output logic              pme_no,
  output logic              irq_no,
  output logic [ST_W-1:0]   status_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic            sys_rst_n;
  mode_t           mode;
  ctrl_t           ctrl;
  logic            link_evt;
  logic            clr_en;
  logic [ST_W-1:0] status;
  logic            unused_wdata;

  assign sys_rst_n    = rst_ni & por_ni;
  assign unused_wdata = ^wr_data_i[DATA_W-1:ST_W];
  assign clr_en       = wr_en_i & (wr_addr_i == ADDR_STAT);

  wake_cfg_regs u_cfg (
    .clk_i      (clk_i),
    .por_ni     (por_ni),
    .rst_ni     (rst_ni),
    .sys_rst_ni (sys_rst_n),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i[MODE_W-1:0]),
    .mode_o     (mode),
    .ctrl_o     (ctrl)
  );

  wake_link_det u_link (
    .clk_i     (clk_i),
    .rst_ni    (sys_rst_n),
    .link_i    (link_i),
    .link_en_i (mode.link_en),
    .evt_o     (link_evt)
  );

  wake_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (sys_rst_n),
    .mode_i     (mode),
    .link_evt_i (link_evt),
    .magic_i    (magic_hit_i),
    .pat_i      (pat_hit_i),
    .clr_en_i   (clr_en),
    .clr_i      (wr_data_i[ST_W-1:0]),
    .status_o   (status)
  );

  assign pme_no   = ~(status[ST_PME] & ctrl.pme_en);
  assign irq_no   = ~(status[ST_MINT] & ctrl.gie & ctrl.mint_en);
  assign status_o = status;
  assign mode_o   = mode;
  assign ctrl_o   = ctrl;

  AST_PME_QUIET_RST: assert property (@(posedge clk_i) disable iff (!por_ni)
    !rst_ni |=> pme_no && irq_no); // R4
  AST_IRQ_AFTER_MAGIC: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    $fell(irq_no) && ctrl.gie && ctrl.mint_en && $stable(ctrl) |-> $rose(status[ST_MINT])); // R6
endmodule

// File: tb/wake_evt_ctrl_bench.sv
module wake_evt_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NROW = 17;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] data = '0;
  logic       link = 1'b0, mag = 1'b0, pat = 1'b0;
  logic       pme_n, irq_n;
  logic [4:0] status;
  logic [2:0] mode, ctrl;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_evt_ctrl u_wake_evt_ctrl (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n),
    .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(data),
    .link_i(link), .magic_hit_i(mag), .pat_hit_i(pat),
    .pme_no(pme_n), .irq_no(irq_n), .status_o(status),
    .mode_o(mode), .ctrl_o(ctrl)
  );

  // {we, addr, data, link, magic, pat, exp_status, exp_pme_n, exp_irq_n}
  localparam logic [20:0] TBL [NROW] = '{
    {1'b1, 2'd0, 8'h07, 1'b0, 1'b0, 1'b0, 5'h00, 1'b1, 1'b1}, // R10 mode
    {1'b1, 2'd1, 8'h07, 1'b0, 1'b0, 1'b0, 5'h00, 1'b1, 1'b1}, // R10 ctrl
    {1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 5'h11, 1'b0, 1'b1}, // R2 R3 R4
    {1'b1, 2'd2, 8'h01, 1'b1, 1'b0, 1'b0, 5'h10, 1'b0, 1'b1}, // R9 partial
    {1'b1, 2'd2, 8'h10, 1'b1, 1'b0, 1'b0, 5'h00, 1'b1, 1'b1}, // R9 pme clear
    {1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 5'h1A, 1'b0, 1'b0}, // R5 R6
    {1'b1, 2'd2, 8'h18, 1'b1, 1'b0, 1'b0, 5'h02, 1'b1, 1'b1}, // R9
    {1'b1, 2'd2, 8'h02, 1'b1, 1'b0, 1'b0, 5'h00, 1'b1, 1'b1}, // R9
    {1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 5'h14, 1'b0, 1'b1}, // R7
    {1'b1, 2'd2, 8'h1F, 1'b1, 1'b0, 1'b1, 5'h14, 1'b0, 1'b1}, // R9 set wins
    {1'b1, 2'd2, 8'h1F, 1'b1, 1'b0, 1'b0, 5'h00, 1'b1, 1'b1}, // R9
    {1'b1, 2'd1, 8'h01, 1'b1, 1'b1, 1'b0, 5'h1A, 1'b0, 1'b1}, // R6 gie off
    {1'b1, 2'd2, 8'h1F, 1'b0, 1'b0, 1'b0, 5'h11, 1'b0, 1'b1}, // R9 link wins
    {1'b1, 2'd2, 8'h1F, 1'b0, 1'b0, 1'b0, 5'h00, 1'b1, 1'b1}, // R9
    {1'b1, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 5'h00, 1'b1, 1'b1}, // R10 mode off
    {1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 5'h00, 1'b1, 1'b1}, // R8 ignored
    {1'b1, 2'd3, 8'hFF, 1'b1, 1'b0, 1'b0, 5'h00, 1'b1, 1'b1}  // R10 addr 3
  };

  function automatic string row_tag(int i);
    case (i)
      0, 1, 14, 16: return "R10";
      2:            return "R2";
      5:            return "R5";
      8:            return "R7";
      11:           return "R6";
      15:           return "R8";
      default:      return "R9";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(logic w, logic [1:0] a, logic [7:0] d, logic l, logic m, logic p);
    @(negedge clk);
    we = w; addr = a; data = d; link = l; mag = m; pat = p;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // reset state
    chk("R1 reset status", {3'b0, status}, 8'h00);
    chk("R1 reset mode", {5'b0, mode}, 8'h00);
    chk("R4 reset pins", {6'b0, pme_n, irq_n}, 8'h03);
    @(negedge clk); por_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0);

    for (int i = 0; i < NROW; i++) begin
      logic [20:0] r;
      r = TBL[i];
      step(r[20], r[19:18], r[17:10], r[9], r[8], r[7]);
      chk({row_tag(i), " status"}, {3'b0, status}, {3'b0, r[6:2]});
      chk({row_tag(i), " pins"}, {6'b0, pme_n, irq_n}, {6'b0, r[1:0]});
    end
    chk("R10 addr3 mode", {5'b0, mode}, 8'h00);
    chk("R10 addr3 ctrl", {5'b0, ctrl}, 8'h01);

    // R1: mode survives bus reset, writes blocked
    step(1, 0, 8'h05, 1, 0, 0);
    step(1, 1, 8'h07, 1, 0, 0);
    step(1, 2, 8'h1F, 1, 0, 0);
    chk("R10 mode 5", {5'b0, mode}, 8'h05);
    @(negedge clk); rst_n = 1'b0;
    step(1, 0, 8'h00, 1, 0, 0);
    step(1, 1, 8'h07, 1, 1, 1);
    chk("R1 mode kept", {5'b0, mode}, 8'h05);
    chk("R1 ctrl cleared", {5'b0, ctrl}, 8'h00);
    chk("R1 status cleared", {3'b0, status}, 8'h00);
    @(negedge clk); we = 1'b0; mag = 1'b0; pat = 1'b0; rst_n = 1'b1;

    // R2: link held high across release is not an edge
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    chk("R2 prime no event", {3'b0, status}, 8'h00);
    step(0, 0, 0, 0, 0, 0);
    chk("R2 falling edge", {3'b0, status}, 8'h11);
    chk("R4 pme_en clear", {7'b0, pme_n}, 8'h01);
    step(1, 1, 8'h01, 0, 0, 0);
    chk("R4 pme_en set", {7'b0, pme_n}, 8'h00);

    // R1: power-on reset clears mode
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    chk("R1 por clears mode", {5'b0, mode}, 8'h00);
    chk("R1 por clears status", {3'b0, status}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule